// File: doc/BRIEF.md
# PCI Interface Bring-Up Sequencer

This block controls the start-up state of a PCI interface unit. The unit can come up in one of two ways. In the first, local firmware brings the unit up and may act as the PCI bus host. In the second, an external host configures the unit while the local processor waits in reset. The block holds the unit inactive after reset and becomes active only when firmware writes an initialization-done bit. It answers configuration cycles with retry while it is inactive and is not the bus host. It keeps either the PCI bus or the local processor in reset until software releases it. It also records outbound master aborts in two sticky flags that software clears.

A watchdog counter raises a sticky timeout flag if initialization has not completed within a configurable number of cycles after reset. Two straps select the mode. `ext_init_strap` chooses initialization by an external host, and it overrides `host_strap`, so the unit is never bus host in that mode. Control writes are single-cycle strobes that carry a 5-bit word. The block has no streaming data path. Every pin is plain control or status, and nothing applies back-pressure.

Top module: `pci_brg_seq`

## Requirements
- R1: After reset `active` is 0. `active` becomes 1 on the clock edge that samples `ctl_wr_en`=1 with `ctl_wr_data[0]`=1, and stays 1 until reset. A write with bit 0 = 0 leaves it at 0.
- R2: `cfg_retry` is 1 in the same cycle as `cfg_req` whenever `active` is 0 and the unit is not bus host. This includes the cycle of the initialization write. `cfg_retry` is never 1 while `active` is 1.
- R3: Bus host mode is `host_strap`=1 with `ext_init_strap`=0. In this mode `pci_rst_out` is 1 from reset until the edge that samples a write with `ctl_wr_data[1]`=1, and 0 afterwards. Configuration cycles are never retried in this mode.
- R4: With `ext_init_strap`=1, `pci_rst_out` is always 0 whatever `host_strap` is, and a write with bit 1 = 1 has no effect on it. `cpu_rst_out` is 1 until the edge that samples a write with `ctl_wr_data[2]`=1. With `ext_init_strap`=0, `cpu_rst_out` is always 0.
- R5: When `ma_evt` is 1 at an edge, both `ma_ctl_flag` and `ma_cmd_flag` are 1 after that edge. A write with `ctl_wr_data[3]`=1 clears `ma_ctl_flag`, and a write with `ctl_wr_data[4]`=1 clears `ma_cmd_flag`. Otherwise each flag holds its value. When a master abort and a clear occur in the same cycle, the flag stays set.
- R6: `init_timeout` becomes 1 at edge number `TIMEOUT_CYCLES` after reset if `active` is still 0 at that point. It stays 1 until reset. It never rises if `active` rose first.
- R7: `data_abort` is 1 for the one cycle after an edge that sampled `ma_evt`=1 while `cpu_rst_out` was 0. It is 0 at all other times, including aborts that occur while the processor is held in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_strap | input | 1 | Requests bus host role (static) |
| ext_init_strap | input | 1 | Initialization by an external host (static) |
| ctl_wr_en | input | 1 | Control write strobe |
| ctl_wr_data | input | 5 | Control word: 0 init done, 1 release bus reset, 2 release processor reset, 3 clear control abort flag, 4 clear command abort flag |
| cfg_req | input | 1 | Configuration cycle targeting the unit |
| cfg_retry | output | 1 | Answer the current configuration cycle with retry |
| ma_evt | input | 1 | Master abort on an outbound read |
| active | output | 1 | Unit initialized and active |
| pci_rst_out | output | 1 | PCI bus reset (bus host mode) |
| cpu_rst_out | output | 1 | Local processor reset (external init mode) |
| ma_ctl_flag | output | 1 | Sticky master-abort flag, control copy |
| ma_cmd_flag | output | 1 | Sticky master-abort flag, command/status copy |
| data_abort | output | 1 | One-cycle abort pulse toward the processor |
| init_timeout | output | 1 | Initialization watchdog expired |

## Verification
The assertions rely on the two straps staying constant while `rst_n` is high. They also rely on `ma_evt` and `ctl_wr_en` being synchronous single-cycle strobes. The bench changes the straps only inside its reset task and drives every strobe for exactly one clock cycle, away from the active edge. Each mode gets a fresh reset, so its release ordering starts from the reset values.

// File: rtl/pci_brg_pkg.sv
package pci_brg_pkg;
  localparam int CTL_W          = 5;
  localparam int CB_INIT_DONE   = 0;
  localparam int CB_BUS_RELEASE = 1;
  localparam int CB_CPU_RELEASE = 2;
  localparam int CB_CLR_MA_CTL  = 3;
  localparam int CB_CLR_MA_CMD  = 4;
endpackage

// File: rtl/pci_brg_state.sv
module pci_brg_state #(
  parameter int TIMEOUT_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_init,
  output logic active,
  output logic init_timeout
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic             active_q;
  logic             tmo_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else if (set_init) begin
      active_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else if (!active_q && !tmo_q) begin
      if (cnt_q == LAST) begin
        tmo_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active       = active_q;
  assign init_timeout = tmo_q;

  AST_ACTIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> active_q); // R1
  AST_ACTIVE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(set_init)); // R1
  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |=> tmo_q); // R6
  AST_TIMEOUT_NOT_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !tmo_q) |=> !tmo_q); // R6
endmodule

// File: rtl/pci_brg_reset_ctl.sv
module pci_brg_reset_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic host_mode,
  input  logic ext_init,
  input  logic rel_bus,
  input  logic rel_cpu,
  output logic pci_rst_out,
  output logic cpu_rst_out
);
  logic bus_hold_q;
  logic cpu_hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_hold_q <= 1'b1;
      cpu_hold_q <= 1'b1;
    end else begin
      if (rel_bus) bus_hold_q <= 1'b0;
      if (rel_cpu) cpu_hold_q <= 1'b0;
    end
  end

  assign pci_rst_out = host_mode & bus_hold_q;
  assign cpu_rst_out = ext_init & cpu_hold_q;

  AST_BUS_RST_NO_REASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    !pci_rst_out |=> !pci_rst_out); // R3
  AST_CPU_RST_NO_REASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rst_out |=> !cpu_rst_out); // R4
  AST_ONE_RESET_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pci_rst_out && cpu_rst_out)); // R4
endmodule

// File: rtl/pci_brg_abort_flags.sv
module pci_brg_abort_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ma_evt,
  input  logic clr_ctl,
  input  logic clr_cmd,
  input  logic cpu_in_rst,
  output logic ma_ctl_flag,
  output logic ma_cmd_flag,
  output logic data_abort
);
  logic ctl_q;
  logic cmd_q;
  logic da_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= 1'b0;
      cmd_q <= 1'b0;
      da_q  <= 1'b0;
    end else begin
      ctl_q <= ma_evt | (ctl_q & ~clr_ctl);
      cmd_q <= ma_evt | (cmd_q & ~clr_cmd);
      da_q  <= ma_evt & ~cpu_in_rst;
    end
  end

  assign ma_ctl_flag = ctl_q;
  assign ma_cmd_flag = cmd_q;
  assign data_abort  = da_q;

  AST_ABORT_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ma_evt |=> (ctl_q && cmd_q)); // R5
  AST_CTL_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q && !clr_ctl) |=> ctl_q); // R5
  AST_CMD_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q && !clr_cmd) |=> cmd_q); // R5
  AST_DA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    data_abort |-> ($past(ma_evt) && !$past(cpu_in_rst))); // R7
endmodule

// File: rtl/pci_brg_seq.sv
module pci_brg_seq
  import pci_brg_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_strap,
  input  logic             ext_init_strap,
  input  logic             ctl_wr_en,
  input  logic [CTL_W-1:0] ctl_wr_data,
  input  logic             cfg_req,
  output logic             cfg_retry,
  input  logic             ma_evt,
  output logic             active,
  output logic             pci_rst_out,
  output logic             cpu_rst_out,
  output logic             ma_ctl_flag,
  output logic             ma_cmd_flag,
  output logic             data_abort,
  output logic             init_timeout
);
  logic             host_mode;
  logic [CTL_W-1:0] wr_bits;

  assign host_mode = host_strap & ~ext_init_strap;
  assign wr_bits   = ctl_wr_en ? ctl_wr_data : '0;

  pci_brg_state #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) state_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_init     (wr_bits[CB_INIT_DONE]),
    .active       (active),
    .init_timeout (init_timeout)
  );

  pci_brg_reset_ctl rst_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_mode   (host_mode),
    .ext_init    (ext_init_strap),
    .rel_bus     (wr_bits[CB_BUS_RELEASE]),
    .rel_cpu     (wr_bits[CB_CPU_RELEASE]),
    .pci_rst_out (pci_rst_out),
    .cpu_rst_out (cpu_rst_out)
  );

  pci_brg_abort_flags flags_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ma_evt      (ma_evt),
    .clr_ctl     (wr_bits[CB_CLR_MA_CTL]),
    .clr_cmd     (wr_bits[CB_CLR_MA_CMD]),
    .cpu_in_rst  (cpu_rst_out),
    .ma_ctl_flag (ma_ctl_flag),
    .ma_cmd_flag (ma_cmd_flag),
    .data_abort  (data_abort)
  );

  assign cfg_retry = cfg_req & ~active & ~host_mode;

  AST_NO_RETRY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !cfg_retry); // R2
  AST_NO_RETRY_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    (host_strap && !ext_init_strap) |-> !cfg_retry); // R3
  AST_EXT_NO_BUS_RST: assert property (@(posedge clk) disable iff (!rst_n)
    ext_init_strap |-> !pci_rst_out); // R4
endmodule

// File: tb/pci_brg_seq_tb.sv
module pci_brg_seq_tb_top;
  localparam int LIMIT = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_strap = 1'b0;
  logic       ext_init_strap = 1'b0;
  logic       ctl_wr_en = 1'b0;
  logic [4:0] ctl_wr_data = '0;
  logic       cfg_req = 1'b0;
  logic       ma_evt = 1'b0;
  logic       cfg_retry, active, pci_rst_out, cpu_rst_out;
  logic       ma_ctl_flag, ma_cmd_flag, data_abort, init_timeout;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pci_brg_seq #(.TIMEOUT_CYCLES(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_strap(host_strap), .ext_init_strap(ext_init_strap),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .cfg_req(cfg_req),
    .cfg_retry(cfg_retry), .ma_evt(ma_evt), .active(active),
    .pci_rst_out(pci_rst_out), .cpu_rst_out(cpu_rst_out),
    .ma_ctl_flag(ma_ctl_flag), .ma_cmd_flag(ma_cmd_flag),
    .data_abort(data_abort), .init_timeout(init_timeout)
  );

  // fields: ma, wr_en, data[4:0], exp_ctl, exp_cmd, exp_da
  localparam logic [9:0] VEC [8] = '{
    {1'b1, 1'b0, 5'b00000, 1'b1, 1'b1, 1'b1},
    {1'b0, 1'b1, 5'b01000, 1'b0, 1'b1, 1'b0},
    {1'b1, 1'b1, 5'b11000, 1'b1, 1'b1, 1'b1},
    {1'b0, 1'b1, 5'b10000, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b0, 5'b00000, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b1, 5'b11000, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b1, 5'b00001, 1'b1, 1'b1, 1'b1},
    {1'b0, 1'b1, 5'b11000, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    ctl_wr_en = 1'b0; ctl_wr_data = '0; ma_evt = 1'b0; cfg_req = 1'b0;
  endtask

  task automatic do_reset(input logic host, input logic ext);
    @(negedge clk);
    rst_n = 1'b0; host_strap = host; ext_init_strap = ext;
    ctl_wr_en = 1'b0; ctl_wr_data = '0; ma_evt = 1'b0; cfg_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [4:0] d);
    ctl_wr_en = 1'b1; ctl_wr_data = d;
    step();
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Local init, device role
    do_reset(1'b0, 1'b0);
    chk("R1", "active after reset", active, 1'b0);
    chk("R3", "pci_rst device role", pci_rst_out, 1'b0);
    chk("R4", "cpu_rst local init", cpu_rst_out, 1'b0);
    chk("R5", "ctl flag after reset", ma_ctl_flag, 1'b0);
    cfg_req = 1'b1; #1;
    chk("R2", "retry while inactive", cfg_retry, 1'b1);
    step();
    wr(5'b00000);
    chk("R1", "write bit0=0 no effect", active, 1'b0);
    cfg_req = 1'b1; ctl_wr_en = 1'b1; ctl_wr_data = 5'b00001; #1;
    chk("R2", "retry in init write cycle", cfg_retry, 1'b1);
    step();
    chk("R1", "active after init write", active, 1'b1);
    cfg_req = 1'b1; #1;
    chk("R2", "no retry when active", cfg_retry, 1'b0);
    step();
    repeat (LIMIT + 2) step();
    chk("R6", "no timeout after early init", init_timeout, 1'b0);

    for (int i = 0; i < 8; i++) begin
      ma_evt = VEC[i][9]; ctl_wr_en = VEC[i][8]; ctl_wr_data = VEC[i][7:3];
      step();
      chk("R5", "ctl flag vector", ma_ctl_flag, VEC[i][2]);
      chk("R5", "cmd flag vector", ma_cmd_flag, VEC[i][1]);
      chk("R7", "data_abort vector", data_abort, VEC[i][0]);
    end
    step();
    chk("R7", "data_abort one cycle", data_abort, 1'b0);

    // Timeout
    do_reset(1'b0, 1'b0);
    repeat (LIMIT - 1) step();
    chk("R6", "timeout before limit", init_timeout, 1'b0);
    step();
    chk("R6", "timeout at limit", init_timeout, 1'b1);
    wr(5'b00001);
    chk("R6", "timeout sticky", init_timeout, 1'b1);
    chk("R1", "active after late init", active, 1'b1);

    // Bus host mode
    do_reset(1'b1, 1'b0);
    chk("R3", "pci_rst held host", pci_rst_out, 1'b1);
    chk("R4", "cpu_rst host mode", cpu_rst_out, 1'b0);
    cfg_req = 1'b1; #1;
    chk("R3", "no retry in host mode", cfg_retry, 1'b0);
    step();
    wr(5'b00100);
    chk("R3", "bit2 keeps bus reset", pci_rst_out, 1'b1);
    wr(5'b00010);
    chk("R3", "bus reset released", pci_rst_out, 1'b0);
    step();
    chk("R3", "bus reset stays low", pci_rst_out, 1'b0);

    // External host init, strap asks for host role
    do_reset(1'b1, 1'b1);
    chk("R4", "no bus reset ext init", pci_rst_out, 1'b0);
    chk("R4", "cpu held ext init", cpu_rst_out, 1'b1);
    cfg_req = 1'b1; #1;
    chk("R2", "retry ext init inactive", cfg_retry, 1'b1);
    step();
    wr(5'b00010);
    chk("R4", "bit1 ignored ext init", pci_rst_out, 1'b0);
    chk("R4", "cpu still held", cpu_rst_out, 1'b1);
    ma_evt = 1'b1;
    step();
    chk("R7", "no data_abort in cpu reset", data_abort, 1'b0);
    chk("R5", "flag set in cpu reset", ma_ctl_flag, 1'b1);
    wr(5'b00100);
    chk("R4", "cpu released", cpu_rst_out, 1'b0);
    ma_evt = 1'b1;
    step();
    chk("R7", "data_abort after release", data_abort, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule